// File: doc/BRIEF.md
# Parametric LLR Table Generator

This block turns a fresh estimate of the two cell-state distributions into the eight log-likelihood ratios that a soft decoder assigns to the 3-bit soft codes. The caller presents the erased-state mean, the programmed-state mean, the reciprocal of their common variance and one representative read voltage for each code. A single update strobe then starts a rebuild of the table. Codes that arrive on the lookup port are mapped to LLRs from the table.

Both states are modelled as Gaussians with one shared sigma, and both symbols are equally likely. Symbol 0 is the programmed state and symbol 1 is the erased state. With these assumptions the LLR is linear in the voltage: LLR(y) = g·(2y − (mE + mP)) / 2, where g = (mP − mE)/σ². The block evaluates this one table entry per cycle through a single shared multiplier. It writes the results into a shadow copy of the table, so lookups keep using the previous table until all eight new entries are in place. A table is rebuilt only when an update is requested, for example after a failed decode.

Top module: `llr_table_gen`

## Requirements
- R1: After reset, `ready_o` and `llr_vld_o` are 0, and every code looked up before the first update returns an LLR of 0.
- R2: Each table entry for code c is round-half-up((iv·(mP − mE)·(2·v_c − mE − mP)) / 2^(IVF+1)), where iv is `inv_var_i` as an unsigned fraction with IVF = 16 fraction bits and v_c is the signed slice `rep_v_i[c*10 +: 10]`.
- R3: Each entry saturates to the range −31..+31. A result above +31 is stored as +31, and a result below −31 is stored as −31.
- R4: When `upd_i` is sampled high while idle, `ready_o` is 0 after that edge. It stays 0 for the next 7 edges and is 1 after the 8th edge.
- R5: A code sampled with `code_vld_i` high appears on `llr_o`, with `llr_vld_o` high, after the next clock edge. In every other cycle `llr_vld_o` is 0.
- R6: Lookups sampled at any of the 8 edges of a rebuild, including the edge that completes it, return the previous table. Lookups sampled after that return the new table.
- R7: An `upd_i` pulse sampled while a rebuild is running has no effect on the rebuild or on the resulting table.
- R8: The parameter inputs are captured only at the accepted update edge. Changes to them during a rebuild do not alter the new table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| upd_i | input | 1 | Request a table rebuild (accepted only when idle) |
| mean_erase_i | input | 10 | Erased-state mean, signed |
| mean_prog_i | input | 10 | Programmed-state mean, signed |
| inv_var_i | input | 16 | 1/σ², unsigned, 16 fraction bits |
| rep_v_i | input | 80 | Eight signed 10-bit representative voltages, code c at bits c*10 and up |
| code_vld_i | input | 1 | Lookup strobe |
| code_i | input | 3 | Soft code to look up |
| ready_o | output | 1 | A completed table is in use and no rebuild is running |
| llr_vld_o | output | 1 | `llr_o` holds a lookup result |
| llr_o | output | 6 | Signed LLR for the code sampled one edge earlier |

## Verification
A lookup result is due one edge after its strobe. The bench drives the strobe on the falling edge and reads `llr_o` shortly after the following rising edge. The ready flag is checked after each of the 8 edges that follow an accepted update; it must be low after the first 7 and high after the 8th. During the same 8 edges the bench issues one lookup per edge and expects the previous table, because the edge that finishes the rebuild still reads the old bank. From the 9th edge on it expects the values that its own reference function computes from the captured parameters.

// File: rtl/llrgen_pkg.sv
package llrgen_pkg;
    localparam int NCODE  = 8;
    localparam int CODE_W = $clog2(NCODE);
endpackage

// File: rtl/llr_eval.sv
// Combinational evaluation of one table entry: gain * (2v - sum), rounded and clipped.
module llr_eval #(
    parameter int VW   = 10,
    parameter int GW   = 28,
    parameter int FRAC = 16,
    parameter int LW   = 6
) (
    input  logic signed [GW-1:0] gain_i,
    input  logic signed [VW-1:0] vrep_i,
    input  logic signed [VW:0]   vsum_i,
    output logic signed [LW-1:0] llr_o
);
    localparam int PW = GW + VW + 2;
    localparam logic signed [PW-1:0] HALF = PW'(1) <<< FRAC;
    localparam logic signed [PW-1:0] LMAX = PW'((1 << (LW-1)) - 1);
    localparam logic signed [PW-1:0] LMIN = -LMAX;

    logic signed [VW+1:0] twice_v, sum_x, diff;
    logic signed [PW-1:0] gain_x, diff_x, prod, rounded, scaled;

    always_comb begin
        twice_v = {vrep_i[VW-1], vrep_i, 1'b0};
        sum_x   = {vsum_i[VW], vsum_i};
        diff    = twice_v - sum_x;
        gain_x  = {{(PW-GW){gain_i[GW-1]}}, gain_i};
        diff_x  = {{(PW-VW-2){diff[VW+1]}}, diff};
        prod    = gain_x * diff_x;
        rounded = prod + HALF;
        scaled  = rounded >>> (FRAC + 1);
        if (scaled > LMAX) begin
            llr_o = LMAX[LW-1:0];
        end else if (scaled < LMIN) begin
            llr_o = LMIN[LW-1:0];
        end else begin
            llr_o = scaled[LW-1:0];
        end
    end
endmodule

// File: rtl/llr_seq.sv
// Captures the parameters, steps the entry index and raises ready after the last entry.
module llr_seq
    import llrgen_pkg::*;
#(
    parameter int VW  = 10,
    parameter int IVW = 16,
    parameter int GW  = IVW + VW + 2
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     upd_i,
    input  logic signed [VW-1:0]     mean_erase_i,
    input  logic signed [VW-1:0]     mean_prog_i,
    input  logic [IVW-1:0]           inv_var_i,
    input  logic [NCODE*VW-1:0]      rep_v_i,
    output logic signed [GW-1:0]     gain_o,
    output logic signed [VW:0]       vsum_o,
    output logic signed [VW-1:0]     vrep_o,
    output logic                     wr_en_o,
    output logic [CODE_W-1:0]        wr_idx_o,
    output logic                     swap_o,
    output logic                     busy_o,
    output logic                     ready_o
);
    localparam logic [CODE_W-1:0] LAST = CODE_W'(NCODE - 1);

    typedef struct packed {
        logic                  busy;
        logic                  ready;
        logic [CODE_W-1:0]     idx;
        logic signed [GW-1:0]  gain;
        logic signed [VW:0]    vsum;
        logic [NCODE*VW-1:0]   reps;
    } seq_t;

    seq_t s_q, s_d;
    logic accept;
    logic signed [VW:0]   dmu;
    logic signed [GW-1:0] iv_x, dmu_x;

    always_comb begin
        s_d    = s_q;
        accept = upd_i && !s_q.busy;
        dmu    = {mean_prog_i[VW-1], mean_prog_i} - {mean_erase_i[VW-1], mean_erase_i};
        iv_x   = {{(GW-IVW){1'b0}}, inv_var_i};
        dmu_x  = {{(GW-VW-1){dmu[VW]}}, dmu};
        if (accept) begin
            s_d.busy  = 1'b1;
            s_d.ready = 1'b0;
            s_d.idx   = '0;
            s_d.gain  = iv_x * dmu_x;
            s_d.vsum  = {mean_erase_i[VW-1], mean_erase_i} + {mean_prog_i[VW-1], mean_prog_i};
            s_d.reps  = rep_v_i;
        end else if (s_q.busy) begin
            s_d.idx = s_q.idx + 1'b1;
            if (s_q.idx == LAST) begin
                s_d.busy  = 1'b0;
                s_d.ready = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign gain_o   = s_q.gain;
    assign vsum_o   = s_q.vsum;
    assign vrep_o   = s_q.reps[s_q.idx*VW +: VW];
    assign wr_en_o  = s_q.busy;
    assign wr_idx_o = s_q.idx;
    assign swap_o   = s_q.busy && (s_q.idx == LAST);
    assign busy_o   = s_q.busy;
    assign ready_o  = s_q.ready;

    // R4: an accepted update withdraws ready and starts the run
    a_r4_accept_drops_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (upd_i && !busy_o) |=> (!ready_o && busy_o));
    // R4: ready only comes back right after the last entry was written
    a_r4_ready_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ready_o) |-> ($past(swap_o) && !busy_o));
    // R7, R8: captured parameters hold while a run is in progress
    a_r7_no_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && upd_i) |=> ($stable(gain_o) && $stable(vsum_o) && $stable(s_q.reps)));
endmodule

// File: rtl/llr_bank.sv
// Two copies of the table: one serves lookups, the other takes new entries.
module llr_bank
    import llrgen_pkg::*;
#(
    parameter int LW = 6
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     wr_en_i,
    input  logic [CODE_W-1:0]        wr_idx_i,
    input  logic signed [LW-1:0]     wr_data_i,
    input  logic                     swap_i,
    input  logic                     rd_en_i,
    input  logic [CODE_W-1:0]        rd_idx_i,
    output logic signed [LW-1:0]     rd_data_o,
    output logic                     rd_vld_o
);
    typedef struct packed {
        logic                              act;
        logic [1:0][NCODE-1:0][LW-1:0]     mem;
        logic [LW-1:0]                     dout;
        logic                              vld;
    } bank_t;

    bank_t b_q, b_d;
    logic  shadow;

    always_comb begin
        b_d    = b_q;
        shadow = ~b_q.act;
        if (wr_en_i) begin
            b_d.mem[shadow][wr_idx_i] = wr_data_i;
        end
        if (swap_i) begin
            b_d.act = shadow;
        end
        b_d.vld = rd_en_i;
        if (rd_en_i) begin
            b_d.dout = b_q.mem[b_q.act][rd_idx_i];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign rd_data_o = b_q.dout;
    assign rd_vld_o  = b_q.vld;

    // R6: the bank serving lookups changes only on a swap
    a_r6_active_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !swap_i |=> $stable(b_q.act));
    // R5: result valid follows the lookup strobe by one edge
    a_r5_vld_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_en_i |=> rd_vld_o);
    a_r5_vld_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> !rd_vld_o);
endmodule

// File: rtl/llr_table_gen.sv
module llr_table_gen
    import llrgen_pkg::*;
#(
    parameter int VW   = 10,
    parameter int IVW  = 16,
    parameter int FRAC = 16,
    parameter int LW   = 6
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     upd_i,
    input  logic signed [VW-1:0]     mean_erase_i,
    input  logic signed [VW-1:0]     mean_prog_i,
    input  logic [IVW-1:0]           inv_var_i,
    input  logic [NCODE*VW-1:0]      rep_v_i,
    input  logic                     code_vld_i,
    input  logic [CODE_W-1:0]        code_i,
    output logic                     ready_o,
    output logic                     llr_vld_o,
    output logic signed [LW-1:0]     llr_o
);
    localparam int GW = IVW + VW + 2;
    localparam logic signed [LW-1:0] LMAX = LW'((1 << (LW-1)) - 1);

    logic signed [GW-1:0]  gain;
    logic signed [VW:0]    vsum;
    logic signed [VW-1:0]  vrep;
    logic signed [LW-1:0]  entry;
    logic                  wr_en, swap, busy;
    logic [CODE_W-1:0]     wr_idx;

    llr_seq #(.VW(VW), .IVW(IVW), .GW(GW)) i_seq (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .upd_i        (upd_i),
        .mean_erase_i (mean_erase_i),
        .mean_prog_i  (mean_prog_i),
        .inv_var_i    (inv_var_i),
        .rep_v_i      (rep_v_i),
        .gain_o       (gain),
        .vsum_o       (vsum),
        .vrep_o       (vrep),
        .wr_en_o      (wr_en),
        .wr_idx_o     (wr_idx),
        .swap_o       (swap),
        .busy_o       (busy),
        .ready_o      (ready_o)
    );

    llr_eval #(.VW(VW), .GW(GW), .FRAC(FRAC), .LW(LW)) i_eval (
        .gain_i (gain),
        .vrep_i (vrep),
        .vsum_i (vsum),
        .llr_o  (entry)
    );

    llr_bank #(.LW(LW)) i_bank (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (entry),
        .swap_i    (swap),
        .rd_en_i   (code_vld_i),
        .rd_idx_i  (code_i),
        .rd_data_o (llr_o),
        .rd_vld_o  (llr_vld_o)
    );

    // R3: every value leaving the block lies in the symmetric range
    a_r3_llr_bounds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        llr_vld_o |-> (llr_o <= LMAX && llr_o >= -LMAX));
    // R4: ready and a running rebuild never coincide
    a_r4_ready_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy |-> !ready_o);
endmodule

// File: tb/test_llr_table_gen.sv
module test_llr_table_gen;
    localparam int CLK_T = 10;
    localparam int VW = 10;
    localparam int IVF = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic upd = 1'b0;
    logic signed [VW-1:0] me = '0, mp = '0;
    logic [15:0] iv = '0;
    logic [8*VW-1:0] reps = '0;
    logic cvld = 1'b0;
    logic [2:0] code = '0;
    logic ready, lvld;
    logic signed [5:0] llr;

    int total = 0;
    int bad = 0;
    int cur_tab [8];
    int new_tab [8];

    always #(CLK_T/2) clk = ~clk;

    llr_table_gen i_llr_table_gen (
        .clk_i(clk), .rst_ni(rst_n), .upd_i(upd), .mean_erase_i(me), .mean_prog_i(mp),
        .inv_var_i(iv), .rep_v_i(reps), .code_vld_i(cvld), .code_i(code),
        .ready_o(ready), .llr_vld_o(lvld), .llr_o(llr)
    );

    function automatic int ref_llr(int e, int p, int ivv, int y);
        longint prod, r;
        prod = longint'(ivv) * longint'(p - e) * longint'(2*y - e - p);
        r = (prod + (longint'(1) <<< IVF)) >>> (IVF + 1);
        if (r > 31) r = 31;
        if (r < -31) r = -31;
        return int'(r);
    endfunction

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_params(int e, int p, int ivv, int v[8]);
        me = VW'(e);
        mp = VW'(p);
        iv = 16'(ivv);
        for (int c = 0; c < 8; c++) reps[c*VW +: VW] = VW'(v[c]);
        for (int c = 0; c < 8; c++) new_tab[c] = ref_llr(e, p, ivv, v[c]);
    endtask

    task automatic lookup(int c, int exp, string req);
        @(negedge clk);
        cvld = 1'b1;
        code = 3'(c);
        @(posedge clk); #1;
        check(req, int'(lvld), 1);
        check(req, int'(llr), exp);
        @(negedge clk);
        cvld = 1'b0;
        @(posedge clk); #1;
        check("R5 vld low", int'(lvld), 0);
    endtask

    // Accepted update; probes with old-table lookups on each of the 8 edges.
    // disturb: extra update pulse and parameter scramble mid-run (R7, R8).
    task automatic run_update(bit disturb);
        @(negedge clk);
        upd = 1'b1;
        @(posedge clk); #1;
        check("R4 ready low after accept", int'(ready), 0);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            upd = disturb && (i == 2);
            if (disturb && i == 1) begin
                me = VW'(-200); mp = VW'(400); iv = 16'hFFFF; reps = {8{VW'(123)}};
            end
            cvld = 1'b1;
            code = 3'(i);
            @(posedge clk); #1;
            check("R6 old table during rebuild", int'(llr), cur_tab[i]);
            check("R4 ready timing", int'(ready), (i == 7) ? 1 : 0);
        end
        @(negedge clk);
        upd = 1'b0;
        cvld = 1'b0;
        for (int c = 0; c < 8; c++) cur_tab[c] = new_tab[c];
        for (int c = 0; c < 8; c++)
            lookup(c, cur_tab[c], disturb ? "R7/R8 table unaffected" : "R2 new table");
    endtask

    initial begin
        #(CLK_T * 200000);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int v[8];
        int seed;
        seed = 32'd7531;
        void'($urandom(seed));
        for (int c = 0; c < 8; c++) cur_tab[c] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 ready reset", int'(ready), 0);
        check("R1 vld reset", int'(lvld), 0);
        lookup(5, 0, "R1 empty table");
        lookup(0, 0, "R1 empty table");

        // R2 directed: iv=41 (~1/1600), means 100/300
        v = '{0, 100, 150, 190, 200, 210, 300, 400};
        set_params(100, 300, 41, v);
        check("R2 midpoint zero", new_tab[4], 0);
        run_update(1'b0);

        // R3 saturation both ways
        v = '{-500, 0, 100, 250, 300, 350, 500, 511};
        set_params(100, 500, 4000, v);
        check("R3 low clip ref", new_tab[0], -31);
        check("R3 high clip ref", new_tab[7], 31);
        run_update(1'b0);

        // equal means: all zero; reversed means: sign flips
        v = '{0, 50, 100, 200, 300, 400, 450, 500};
        set_params(250, 250, 9000, v);
        run_update(1'b0);
        set_params(350, 150, 60, v);
        run_update(1'b0);

        // R7 / R8 disturbance
        v = '{120, 160, 180, 195, 205, 220, 240, 280};
        set_params(150, 250, 200, v);
        run_update(1'b1);

        // random tables
        for (int n = 0; n < 20; n++) begin
            int e, p;
            e = int'($urandom_range(0, 250));
            p = int'($urandom_range(150, 500));
            for (int c = 0; c < 8; c++) v[c] = int'($urandom_range(0, 511)) - 40;
            set_params(e, p, int'($urandom_range(0, 400)), v);
            run_update(n % 5 == 4);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule